// File: doc/BRIEF.md
# Multi-Width ALU Condition-Code Register

This block holds an 8-bit processor condition-code register and the 32-bit adder/subtractor that feeds its arithmetic flags. One operation is issued per cycle. It carries two operands, an operand size (byte, word or longword) and one of six arithmetic operations. The sum or difference goes to a result register. The half-carry, negative, zero, overflow and carry flags are updated from the same cycle's arithmetic. Add-with-carry and subtract-with-borrow take their carry-in from the stored carry flag, so wide values can be chained across several operations.

Software can load the whole register, apply an AND, OR or XOR immediate to it, and read it back at any time on `ccr_q`. Bit 7 is an interrupt mask. Reset sets it, and so does the start of an exception. The block drives a maskable-interrupt enable that is its inverse. Instruction decode, branch evaluation and interrupt arbitration live outside the block.

Register layout, bit 7 down to bit 0: I (mask), UI (user), H, U (user), N, Z, V, C.

Top module: `ccr_alu`

## Requirements
- R1: After reset `ccr_q` is 8'h80 (I set, every other bit 0), `irq_en` is 0 and `result` is 0.
- R2: H is the carry (for add operations) or the borrow (for subtract, compare and negate) out of bit 3 for byte size (`size_sel`=0), out of bit 11 for word size (1), and out of bit 27 for longword size (2 or 3).
- R3: C is the carry or borrow out of the most significant bit of the active size. Add-with-carry (`op_sel`=1) and subtract-with-borrow (3) add or subtract the stored C. Add (0), subtract (2), compare (4) and negate (5) ignore the stored C.
- R4: N is the most significant bit of the result at the active size. Z is 1 exactly when the size-masked result is zero.
- R5: V is 1 when the operation overflows as a two's-complement signed operation at the active size, and 0 otherwise.
- R6: Compare (4) updates H, N, Z, V and C as a subtract would, and leaves `result` unchanged. Negate (5) computes 0 minus `opa`.
- R7: `sw_op` selects a software action on the whole register: 0 none, 1 load `sw_imm`, 2 AND with `sw_imm`, 3 OR with `sw_imm`, 4 XOR with `sw_imm`. The result is visible on `ccr_q` one cycle later. UI (bit 6) and U (bit 4) change only through these actions.
- R8: `exc_start` sets I (bit 7) on the next edge. When it coincides with a software action that would clear I, I is still set.
- R9: `irq_en` is 1 exactly when I is 0.
- R10: When a software action (`sw_op` 1 to 4) and an arithmetic operation arrive in the same cycle, the software action decides the register's bits. The arithmetic result is still written to `result`.
- R11: `result` bits above the active size are 0 after any operation that writes it.
- R12: `op_sel` values 6 and 7 are ignored: neither `result` nor `ccr_q` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Arithmetic operation present this cycle |
| op_sel | input | 3 | 0 add, 1 add-with-carry, 2 sub, 3 sub-with-borrow, 4 compare, 5 negate |
| size_sel | input | 2 | 0 byte, 1 word, 2 or 3 longword |
| opa | input | 32 | First operand (operand of negate) |
| opb | input | 32 | Second operand |
| sw_op | input | 3 | Software register action, encoding in R7 |
| sw_imm | input | 8 | Immediate for software actions |
| exc_start | input | 1 | Exception sequence begins |
| result | output | 32 | Registered arithmetic result |
| ccr_q | output | 8 | Condition-code register contents |
| irq_en | output | 1 | Maskable interrupts allowed |

## Verification
Every input takes effect on the rising edge after it is presented. `result`, `ccr_q` and `irq_en` are therefore due exactly one edge after the stimulus, and no result is due in the stimulus cycle itself. The bench drives each stimulus on a falling edge and removes it before the next rising edge. It compares the outputs on the following falling edge, half a period after they settle. Chained tests depend on the stored carry, so the bench keeps its own expected copy of the register, updates it once per issued action, and uses that copy's C as the carry-in for its reference model.

// File: rtl/ccr_alu.sv
module ccr_alu #(
  parameter int DW  = 32,
  parameter int RW  = 8,
  parameter int OPW = 3,
  parameter int SZW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_sel,
  input  logic [SZW-1:0] size_sel,
  input  logic [DW-1:0]  opa,
  input  logic [DW-1:0]  opb,
  input  logic [2:0]     sw_op,
  input  logic [RW-1:0]  sw_imm,
  input  logic           exc_start,
  output logic [DW-1:0]  result,
  output logic [RW-1:0]  ccr_q,
  output logic           irq_en
);
  localparam int BI = 7, BH = 5, BN = 3, BZ = 2, BV = 1, BC = 0;
  localparam logic [OPW-1:0] K_ADD = 0, K_ADC = 1, K_SUB = 2, K_SBB = 3, K_CMP = 4, K_NEG = 5;
  localparam logic [2:0] S_LD = 1, S_AND = 2, S_OR = 3, S_XOR = 4;

  logic [5:0]    top_i;
  logic [4:0]    half_i;
  logic [DW-1:0] mask;

  always_comb begin
    case (size_sel)
      2'd0:    begin top_i = 6'd7;  half_i = 5'd4;  mask = 32'h0000_00FF; end
      2'd1:    begin top_i = 6'd15; half_i = 5'd12; mask = 32'h0000_FFFF; end
      default: begin top_i = 6'd31; half_i = 5'd28; mask = 32'hFFFF_FFFF; end
    endcase
  end

  wire arith   = op_valid && (op_sel <= K_NEG);
  wire is_sub  = (op_sel == K_SUB) || (op_sel == K_SBB) || (op_sel == K_CMP) || (op_sel == K_NEG);
  wire cin     = ((op_sel == K_ADC) || (op_sel == K_SBB)) && ccr_q[BC];

  wire [DW-1:0] xa = (op_sel == K_NEG) ? '0 : (opa & mask);
  wire [DW-1:0] xb = (op_sel == K_NEG) ? (opa & mask) : (opb & mask);

  wire [DW:0] raw = is_sub ? ({1'b0, xa} - {1'b0, xb} - {{DW{1'b0}}, cin})
                           : ({1'b0, xa} + {1'b0, xb} + {{DW{1'b0}}, cin});

  wire [DW-1:0] res_m = raw[DW-1:0] & mask;
  wire f_c = raw[top_i + 6'd1];
  wire f_h = xa[half_i] ^ xb[half_i] ^ raw[half_i];
  wire sa  = xa[top_i[4:0]];
  wire sb  = xb[top_i[4:0]];
  wire sr  = raw[top_i];
  wire f_v = is_sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
  wire f_n = sr;
  wire f_z = (res_m == '0);

  logic [RW-1:0] ccr_d;
  always_comb begin
    ccr_d = ccr_q;
    if (arith) begin
      ccr_d[BH] = f_h;
      ccr_d[BN] = f_n;
      ccr_d[BZ] = f_z;
      ccr_d[BV] = f_v;
      ccr_d[BC] = f_c;
    end
    case (sw_op)
      S_LD:    ccr_d = sw_imm;
      S_AND:   ccr_d = ccr_q & sw_imm;
      S_OR:    ccr_d = ccr_q | sw_imm;
      S_XOR:   ccr_d = ccr_q ^ sw_imm;
      default: ;
    endcase
    if (exc_start) ccr_d[BI] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q  <= 8'h80;
      result <= '0;
    end else begin
      ccr_q <= ccr_d;
      if (arith && (op_sel != K_CMP)) result <= res_m;
    end
  end

  assign irq_en = ~ccr_q[BI];
endmodule

module ccr_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_sel,
  input logic [1:0]  size_sel,
  input logic [2:0]  sw_op,
  input logic        exc_start,
  input logic [31:0] result,
  input logic [7:0]  ccr_q,
  input logic        irq_en
);
  a_r8_exc_sets_i: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start |=> ccr_q[7]);
  a_r9_exc_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start |=> !irq_en);
  a_r7_user_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_op == 3'd0) |=> ($stable(ccr_q[6]) && $stable(ccr_q[4])));
  a_r6_cmp_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 3'd4) |=> $stable(result));
  a_r11_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel <= 3'd5 && op_sel != 3'd4 && size_sel == 2'd0) |=> (result[31:8] == 24'd0));
  a_r4_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel <= 3'd5 && op_sel != 3'd4 && sw_op == 3'd0) |=> (ccr_q[2] == (result == 32'd0)));
  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((!op_valid || op_sel > 3'd5) && sw_op == 3'd0 && !exc_start) |=> ($stable(ccr_q) && $stable(result)));
endmodule

bind ccr_alu ccr_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel), .size_sel(size_sel),
  .sw_op(sw_op), .exc_start(exc_start), .result(result), .ccr_q(ccr_q), .irq_en(irq_en)
);

// File: tb/ccr_alu_tb.sv
`timescale 1ns/100ps
module ccr_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [1:0]  size_sel = '0;
  logic [31:0] opa = '0, opb = '0;
  logic [2:0]  sw_op = '0;
  logic [7:0]  sw_imm = '0;
  logic        exc_start = 1'b0;
  logic [31:0] result;
  logic [7:0]  ccr_q;
  logic        irq_en;

  int checks = 0;
  int errors = 0;
  logic [7:0]  exp_ccr;
  logic [31:0] exp_res;

  always #2.5 clk = ~clk;

  ccr_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel), .size_sel(size_sel),
    .opa(opa), .opb(opb), .sw_op(sw_op), .sw_imm(sw_imm), .exc_start(exc_start),
    .result(result), .ccr_q(ccr_q), .irq_en(irq_en)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model: flags packed as {H,N,Z,V,C}
  function automatic void model(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] a,
                                input logic [31:0] b, input logic cst,
                                output logic [31:0] r, output logic [4:0] f);
    int n, ht;
    longint one, mask, hm, x, y, ci, full, hx, sx, sy, s, half;
    logic sub;
    one = 1;
    n  = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    ht = (sz == 0) ? 3 : (sz == 1) ? 11 : 27;
    mask = (one << n) - 1;
    hm   = (one << (ht + 1)) - 1;
    half = one << (n - 1);
    x  = (op == 5) ? 0 : (longint'(a) & mask);
    y  = (op == 5) ? (longint'(a) & mask) : (longint'(b) & mask);
    ci = ((op == 1) || (op == 3)) ? longint'(cst) : 0;
    sub = (op >= 2);
    sx = (x >= half) ? x - (one << n) : x;
    sy = (y >= half) ? y - (one << n) : y;
    if (sub) begin
      full = x - y - ci;
      hx   = (x & hm) - (y & hm) - ci;
      f[4] = (hx < 0);
      f[0] = (full < 0);
      s    = sx - sy - ci;
    end else begin
      full = x + y + ci;
      hx   = (x & hm) + (y & hm) + ci;
      f[4] = ((hx >> (ht + 1)) & 1) != 0;
      f[0] = ((full >> n) & 1) != 0;
      s    = sx + sy + ci;
    end
    r    = 32'(full & mask);
    f[3] = ((longint'(r) >> (n - 1)) & 1) != 0;
    f[2] = (r == 0);
    f[1] = (s < -half) || (s >= half);
  endfunction

  task automatic arith(input string req, input logic [2:0] op, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    logic [4:0] f;
    model(op, sz, a, b, exp_ccr[0], r, f);
    exp_ccr = {exp_ccr[7:6], f[4], exp_ccr[4], f[3:0]};
    if (op != 3'd4) exp_res = r;
    @(negedge clk);
    op_valid = 1'b1; op_sel = op; size_sel = sz; opa = a; opb = b;
    @(negedge clk);
    op_valid = 1'b0;
    check(req, "result", result, exp_res);
    check(req, "ccr", {24'd0, ccr_q}, {24'd0, exp_ccr});
  endtask

  task automatic swact(input string req, input logic [2:0] act, input logic [7:0] imm);
    case (act)
      3'd1: exp_ccr = imm;
      3'd2: exp_ccr = exp_ccr & imm;
      3'd3: exp_ccr = exp_ccr | imm;
      3'd4: exp_ccr = exp_ccr ^ imm;
      default: ;
    endcase
    @(negedge clk);
    sw_op = act; sw_imm = imm;
    @(negedge clk);
    sw_op = 3'd0;
    check(req, "ccr", {24'd0, ccr_q}, {24'd0, exp_ccr});
    check("R9", "irq_en", {31'd0, irq_en}, {31'd0, ~exp_ccr[7]});
  endtask

  task automatic t_reset;
    check("R1", "ccr after reset", {24'd0, ccr_q}, 32'h80);
    check("R1", "irq_en after reset", {31'd0, irq_en}, 32'd0);
    check("R1", "result after reset", result, 32'd0);
    exp_ccr = 8'h80; exp_res = 32'd0;
  endtask

  task automatic t_byte;
    arith("R2", 3'd0, 2'd0, 32'h0000_000F, 32'h0000_0001);
    check("R2", "H byte tap", {31'd0, ccr_q[5]}, 32'd1);
    arith("R5", 3'd0, 2'd0, 32'h0000_0080, 32'h0000_0080);
    check("R4", "Z byte", {31'd0, ccr_q[2]}, 32'd1);
    check("R3", "C byte", {31'd0, ccr_q[0]}, 32'd1);
    arith("R11", 3'd0, 2'd0, 32'hFFFF_FF7F, 32'h1234_5601);
    check("R11", "upper bits", {8'd0, result[31:8]}, 32'd0);
    arith("R2", 3'd2, 2'd0, 32'h0000_0010, 32'h0000_0001);
  endtask

  task automatic t_word;
    arith("R2", 3'd0, 2'd1, 32'h0000_0FFF, 32'h0000_0001);
    check("R2", "H word tap", {31'd0, ccr_q[5]}, 32'd1);
    arith("R2", 3'd0, 2'd1, 32'h0000_000F, 32'h0000_0001);
    check("R2", "H word not bit3", {31'd0, ccr_q[5]}, 32'd0);
    arith("R5", 3'd2, 2'd1, 32'h0000_8000, 32'h0000_0001);
    arith("R4", 3'd2, 2'd1, 32'h0000_0001, 32'h0000_0002);
  endtask

  task automatic t_long;
    arith("R2", 3'd0, 2'd2, 32'h0FFF_FFFF, 32'h0000_0001);
    check("R2", "H long tap", {31'd0, ccr_q[5]}, 32'd1);
    arith("R3", 3'd0, 2'd3, 32'hFFFF_FFFF, 32'h0000_0001);
    arith("R5", 3'd0, 2'd2, 32'h7FFF_FFFF, 32'h0000_0001);
    arith("R3", 3'd2, 2'd2, 32'h0000_0000, 32'h0000_0001);
  endtask

  task automatic t_chain;
    arith("R3", 3'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001);
    arith("R3", 3'd1, 2'd0, 32'h0000_0010, 32'h0000_0020);
    check("R3", "adc uses C", result, 32'h31);
    arith("R3", 3'd2, 2'd0, 32'h0000_0000, 32'h0000_0001);
    arith("R3", 3'd3, 2'd1, 32'h0000_1000, 32'h0000_0001);
    check("R3", "sbb uses C", result, 32'hFFE);
    arith("R3", 3'd2, 2'd0, 32'h0000_0000, 32'h0000_0001);
    arith("R3", 3'd0, 2'd0, 32'h0000_0005, 32'h0000_0003);
    check("R3", "plain add ignores C", result, 32'h8);
  endtask

  task automatic t_cmp_neg;
    arith("R6", 3'd0, 2'd2, 32'h1234_5678, 32'h0000_0000);
    arith("R6", 3'd4, 2'd2, 32'h0000_0005, 32'h0000_0005);
    check("R6", "cmp keeps result", result, 32'h1234_5678);
    check("R6", "cmp sets Z", {31'd0, ccr_q[2]}, 32'd1);
    arith("R6", 3'd5, 2'd0, 32'h0000_0080, 32'h0000_0000);
    check("R6", "neg of 0x80 byte V", {31'd0, ccr_q[1]}, 32'd1);
    arith("R6", 3'd5, 2'd1, 32'h0000_0001, 32'h0000_0000);
    check("R6", "neg word value", result, 32'hFFFF);
  endtask

  task automatic t_sw;
    swact("R7", 3'd1, 8'h50);
    swact("R7", 3'd3, 8'h81);
    swact("R7", 3'd4, 8'hFF);
    swact("R7", 3'd2, 8'h0F);
    swact("R7", 3'd1, 8'h50);
    arith("R7", 3'd0, 2'd0, 32'h0000_00FF, 32'h0000_00FF);
    check("R7", "UI/U survive arithmetic", {30'd0, ccr_q[6], ccr_q[4]}, 32'd3);
  endtask

  task automatic t_exc;
    swact("R9", 3'd1, 8'h00);
    check("R9", "irq_en with I clear", {31'd0, irq_en}, 32'd1);
    @(negedge clk);
    exc_start = 1'b1; sw_op = 3'd1; sw_imm = 8'h2A;
    @(negedge clk);
    exc_start = 1'b0; sw_op = 3'd0;
    exp_ccr = 8'hAA;
    check("R8", "exception beats software load", {24'd0, ccr_q}, 32'hAA);
    check("R9", "irq_en after exception", {31'd0, irq_en}, 32'd0);
  endtask

  task automatic t_sw_over_arith;
    @(negedge clk);
    op_valid = 1'b1; op_sel = 3'd0; size_sel = 2'd0; opa = 32'h0F; opb = 32'h01;
    sw_op = 3'd1; sw_imm = 8'h03;
    @(negedge clk);
    op_valid = 1'b0; sw_op = 3'd0;
    exp_ccr = 8'h03; exp_res = 32'h10;
    check("R10", "software wins flags", {24'd0, ccr_q}, 32'h03);
    check("R10", "result still written", result, 32'h10);
  endtask

  task automatic t_illegal;
    @(negedge clk);
    op_valid = 1'b1; op_sel = 3'd6; size_sel = 2'd2; opa = 32'hFFFF_FFFF; opb = 32'h1;
    @(negedge clk);
    op_sel = 3'd7;
    @(negedge clk);
    op_valid = 1'b0;
    check("R12", "result held", result, exp_res);
    check("R12", "ccr held", {24'd0, ccr_q}, {24'd0, exp_ccr});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte();
    t_word();
    t_long();
    t_chain();
    t_cmp_neg();
    t_sw();
    t_exc();
    t_sw_over_arith();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule